// File: doc/BRIEF.md
# Flash Command Sequencer with Error Status

This block sits between a CPU-side synchronous bus and the controller of an embedded flash array. It decodes flash commands that take two bus write cycles: Program, Block Erase, Erase All Unlocked Blocks and Lock Bit Program. It also decodes three single-cycle commands: Read Array, Read Status and Clear Status. It keeps one lock bit per block and honours a global lock-disable input. It issues single-cycle start requests to an abstract array engine and folds the engine's pass/fail result into two sticky error flags. Those two flags together encode three kinds of error: a command-sequence error, an erase error or a program error.

A bus read returns either the array data, which the block passes through unchanged in read-array mode, or a status byte in status mode. Every two-cycle command switches the block into status mode. The CPU polls the ready bit and then examines the error flags. The array physics and the timing of each operation belong to the engine and are outside this block.

Top module: `flash_cmd_seq`

## Requirements
- R1: After reset the block is in read-array mode (`bus_rdata` equals `arr_rdata`), no error flag is set, every lock bit is clear and the block is ready.
- R2: A write whose low data byte is 0x70 selects status mode. A write with 0xFF selects read-array mode. In status mode `bus_rdata` is zero except bit 7 = ready, bit 5 = erase flag and bit 4 = program flag. So status 0x80 means idle with no error, 0xA0 means erase error, 0x90 means program error and 0xB0 means sequence error.
- R3: The recognised first-cycle codes are 0x40 program, 0x20 block erase, 0xA7 erase all, 0x77 lock bit, 0x50 clear status, 0x70 and 0xFF. Any other first-cycle code sets both flags (sequence error), selects status mode and starts nothing.
- R4: In the second cycle of a block erase, an erase all or a lock bit command, a low byte other than 0xD0 or 0xFF sets both flags and starts nothing.
- R5: A second-cycle low byte of 0xFF cancels the pending command. It starts nothing, sets no flag and returns to read-array mode.
- R6: A block erase confirmed on a locked block while `lock_dis` is 0 sets only the erase flag and starts nothing. While `lock_dis` is 1, the same erase runs normally.
- R7: When the engine reports a failure, an erase sets only the erase flag. A program or a lock bit program sets only the program flag.
- R8: The flags stay set until a Clear Status (0x50) write. While any flag is set, the first cycle of a program, erase, erase all or lock command sets both flags and starts nothing.
- R9: `eng_start` lasts exactly one cycle. Ready reads 0 from the confirming write until the engine's done pulse. The flags change in the same cycle that ready returns to 1 and never while busy between done pulses.
- R10: Erase All starts one erase (`eng_op` = 1) per block, in ascending block index. It skips blocks whose lock bit is set unless `lock_dis` is 1, and it visits every remaining block even after a failure.
- R11: A lock bit program that the engine passes sets that block's lock bit. A failing one leaves the bit unchanged.
- R12: Bus writes made while the block is busy have no effect on mode, flags or commands.
- R13: Program takes the block index from the top address bits of its second cycle. It hands the engine `eng_op` = 0 with the second-cycle address and data. Lock bit program uses `eng_op` = 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W | Bus address; the top bits select the block |
| bus_wdata | input | DATA_W | Bus write data; the low byte carries command codes |
| bus_we | input | 1 | Write strobe, one cycle per bus write |
| bus_rdata | output | DATA_W | Array data or status byte |
| arr_rdata | input | DATA_W | Data read from the array |
| lock_dis | input | 1 | Ignore lock bits when set |
| eng_start | output | 1 | One-cycle operation start |
| eng_op | output | 2 | 0 program, 1 erase, 2 lock bit program |
| eng_blk | output | BLK_W | Target block |
| eng_addr | output | ADDR_W | Target address |
| eng_wdata | output | DATA_W | Program data |
| eng_done | input | 1 | One-cycle completion pulse |
| eng_fail | input | 1 | Failure qualifier, valid with eng_done |

## Verification
The hardest situation to reach is an Erase All over a mix of locked and unlocked blocks. Lock bits can only be set, so the bench builds the lock pattern step by step with successful lock bit programs. It then runs Erase All with lock-disable both off and on after each step, comparing the logged start sequence against the order computed from its own lock model. The bench also reaches the busy-window case: it issues writes while a deliberately slow engine stub holds the operation open, and checks that these writes leave mode and flags untouched.

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq #(
  parameter int NUM_BLK = 4,
  parameter int ADDR_W  = 8,
  parameter int DATA_W  = 16,
  localparam int BLK_W  = $clog2(NUM_BLK)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_we,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [DATA_W-1:0] arr_rdata,
  input  logic              lock_dis,
  output logic              eng_start,
  output logic [1:0]        eng_op,
  output logic [BLK_W-1:0]  eng_blk,
  output logic [ADDR_W-1:0] eng_addr,
  output logic [DATA_W-1:0] eng_wdata,
  input  logic              eng_done,
  input  logic              eng_fail
);
  localparam logic [7:0] K_PROG  = 8'h40;
  localparam logic [7:0] K_ERASE = 8'h20;
  localparam logic [7:0] K_ERALL = 8'hA7;
  localparam logic [7:0] K_LOCK  = 8'h77;
  localparam logic [7:0] K_CLEAR = 8'h50;
  localparam logic [7:0] K_STAT  = 8'h70;
  localparam logic [7:0] K_ARRAY = 8'hFF;
  localparam logic [7:0] K_GO    = 8'hD0;

  typedef enum logic [1:0] {S_IDLE, S_WAIT2, S_ISSUE, S_RUN} state_t;
  typedef enum logic [1:0] {C_PROG, C_ERASE, C_ERALL, C_LOCK} cmd_t;

  state_t             state;
  cmd_t               cmd;
  logic [BLK_W-1:0]   cur;
  logic               eflag, pflag, stat_mode;
  logic [NUM_BLK-1:0] lock;

  wire [7:0]       code     = bus_wdata[7:0];
  wire             ready    = (state == S_IDLE) || (state == S_WAIT2);
  wire             wr       = bus_we && ready;
  wire [BLK_W-1:0] wblk     = bus_addr[ADDR_W-1 -: BLK_W];
  wire             eligible = (cmd != C_ERALL) || !lock[cur] || lock_dis;
  wire             last     = (cur == BLK_W'(NUM_BLK - 1));
  wire             errored  = eflag || pflag;
  wire             is_erase = (cmd == C_ERASE) || (cmd == C_ERALL);

  assign eng_start = (state == S_ISSUE) && eligible;
  assign eng_blk   = cur;
  assign eng_op    = (cmd == C_PROG) ? 2'd0 : (cmd == C_LOCK) ? 2'd2 : 2'd1;
  assign bus_rdata = stat_mode ? {{(DATA_W-8){1'b0}}, ready, 1'b0, eflag, pflag, 4'b0000}
                               : arr_rdata;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      cmd       <= C_PROG;
      cur       <= '0;
      eng_addr  <= '0;
      eng_wdata <= '0;
      eflag     <= 1'b0;
      pflag     <= 1'b0;
      stat_mode <= 1'b0;
      lock      <= '0;
    end else begin
      case (state)
        S_IDLE: if (wr) begin
          case (code)
            K_ARRAY: stat_mode <= 1'b0;
            K_STAT:  stat_mode <= 1'b1;
            K_CLEAR: begin eflag <= 1'b0; pflag <= 1'b0; end
            K_PROG, K_ERASE, K_ERALL, K_LOCK: begin
              stat_mode <= 1'b1;
              if (errored) begin
                eflag <= 1'b1;
                pflag <= 1'b1;
              end else begin
                state <= S_WAIT2;
                cmd   <= (code == K_PROG)  ? C_PROG  :
                         (code == K_ERASE) ? C_ERASE :
                         (code == K_ERALL) ? C_ERALL : C_LOCK;
              end
            end
            default: begin
              stat_mode <= 1'b1;
              eflag     <= 1'b1;
              pflag     <= 1'b1;
            end
          endcase
        end
        S_WAIT2: if (wr) begin
          if (cmd == C_PROG) begin
            eng_addr  <= bus_addr;
            eng_wdata <= bus_wdata;
            cur       <= wblk;
            state     <= S_ISSUE;
          end else if (code == K_GO) begin
            eng_addr <= bus_addr;
            cur      <= (cmd == C_ERALL) ? '0 : wblk;
            if (cmd == C_ERASE && lock[wblk] && !lock_dis) begin
              eflag <= 1'b1;
              state <= S_IDLE;
            end else begin
              state <= S_ISSUE;
            end
          end else if (code == K_ARRAY) begin
            stat_mode <= 1'b0;
            state     <= S_IDLE;
          end else begin
            eflag <= 1'b1;
            pflag <= 1'b1;
            state <= S_IDLE;
          end
        end
        S_ISSUE: begin
          if (eligible)  state <= S_RUN;
          else if (last) state <= S_IDLE;
          else           cur   <= cur + 1'b1;
        end
        S_RUN: if (eng_done) begin
          if (eng_fail) begin
            if (is_erase) eflag <= 1'b1;
            else          pflag <= 1'b1;
          end else if (cmd == C_LOCK) begin
            lock[cur] <= 1'b1;
          end
          if (cmd == C_ERALL && !last) begin
            cur   <= cur + 1'b1;
            state <= S_ISSUE;
          end else begin
            state <= S_IDLE;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/flash_cmd_seq_chk.sv
module flash_cmd_seq_chk #(
  parameter int NUM_BLK = 4,
  localparam int BLK_W  = $clog2(NUM_BLK)
) (
  input logic               clk,
  input logic               rst_n,
  input logic               ready,
  input logic               eflag,
  input logic               pflag,
  input logic               eng_start,
  input logic               eng_done,
  input logic [1:0]         eng_op,
  input logic [BLK_W-1:0]   eng_blk,
  input logic [NUM_BLK-1:0] lock,
  input logic               lock_dis,
  input logic               bus_we,
  input logic [7:0]         code
);
  wire clr_wr = ready && bus_we && (code == 8'h50);

  AST_START_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n) eng_start |=> !eng_start); // R9
  AST_BUSY_AFTER_START: assert property (@(posedge clk) disable iff (!rst_n) eng_start |=> !ready); // R9
  AST_FLAGS_HOLD_BUSY: assert property (@(posedge clk) disable iff (!rst_n) (!ready && !eng_done) |=> ($stable(eflag) && $stable(pflag))); // R9
  AST_ERASE_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n) (eflag && !clr_wr) |=> eflag); // R8
  AST_PROG_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n) (pflag && !clr_wr) |=> pflag); // R8
  AST_LOCKED_ERASE_SKIPPED: assert property (@(posedge clk) disable iff (!rst_n) (eng_start && eng_op == 2'd1 && lock[eng_blk]) |-> lock_dis); // R10
endmodule

bind flash_cmd_seq flash_cmd_seq_chk #(.NUM_BLK(NUM_BLK)) u_chk (
  .clk(clk), .rst_n(rst_n), .ready(ready), .eflag(eflag), .pflag(pflag),
  .eng_start(eng_start), .eng_done(eng_done), .eng_op(eng_op), .eng_blk(eng_blk),
  .lock(lock), .lock_dis(lock_dis), .bus_we(bus_we), .code(bus_wdata[7:0])
);

// File: tb/test_flash_cmd_seq.sv
module test_flash_cmd_seq;
  localparam int NB = 4, AW = 8, DW = 16, BW = 2, LAT = 6;
  localparam logic [DW-1:0] ARR = 16'hA5C3;

  logic clk = 0, rst_n = 0;
  logic [AW-1:0] bus_addr = '0;
  logic [DW-1:0] bus_wdata = '0, bus_rdata;
  logic bus_we = 0, lock_dis = 0;
  logic eng_start, eng_done = 0, eng_fail = 0;
  logic [1:0] eng_op;
  logic [BW-1:0] eng_blk;
  logic [AW-1:0] eng_addr;
  logic [DW-1:0] eng_wdata;

  always #4 clk = ~clk;

  flash_cmd_seq #(.NUM_BLK(NB), .ADDR_W(AW), .DATA_W(DW)) i_flash_cmd_seq (
    .clk, .rst_n, .bus_addr, .bus_wdata, .bus_we, .bus_rdata, .arr_rdata(ARR),
    .lock_dis, .eng_start, .eng_op, .eng_blk, .eng_addr, .eng_wdata, .eng_done, .eng_fail);

  // behavioural engine stub
  logic [NB-1:0] fail_mask = '0;
  int n_st = 0, cnt = 0;
  logic [1:0] log_op[64];
  logic [BW-1:0] log_blk[64];
  logic [AW-1:0] log_addr[64];
  logic [DW-1:0] log_data[64];
  logic [BW-1:0] run_blk;
  always @(posedge clk) begin
    eng_done <= 0;
    eng_fail <= 0;
    if (eng_start) begin
      log_op[n_st % 64] <= eng_op;  log_blk[n_st % 64] <= eng_blk;
      log_addr[n_st % 64] <= eng_addr; log_data[n_st % 64] <= eng_wdata;
      n_st <= n_st + 1; cnt <= LAT; run_blk <= eng_blk;
    end else if (cnt > 0) begin
      if (cnt == 1) begin eng_done <= 1; eng_fail <= fail_mask[run_blk]; end
      cnt <= cnt - 1;
    end
  end

  int checks = 0, fails = 0;
  logic [NB-1:0] lk = '0;
  bit finished = 0;

  task automatic chk(input logic [DW-1:0] act, input logic [DW-1:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_we = 1;
    @(negedge clk); bus_we = 0;
  endtask

  task automatic wait_ready(input string tag);
    bit seen = 0;
    for (int i = 0; i < 200 && !seen; i++) begin
      if (bus_rdata[7]) seen = 1; else @(negedge clk);
    end
    chk({15'd0, seen}, 16'd1, tag);
  endtask

  function automatic logic [AW-1:0] baddr(input int b);
    return AW'((b << (AW - BW)) | (b * 5 + 1));
  endfunction

  task automatic erase_all_check(input string tag);
    int n0 = n_st, k = 0;
    logic [DW-1:0] st = 16'h80;
    wr(0, 16'hA7); wr(0, 16'hD0);
    wait_ready(tag);
    for (int b = 0; b < NB; b++)
      if (!lk[b] || lock_dis) begin
        chk({14'd0, log_blk[(n0 + k) % 64]}, 16'(b), {tag, " R10 order"});
        chk({14'd0, log_op[(n0 + k) % 64]}, 16'd1, {tag, " R10 op"});
        if (fail_mask[b]) st = 16'hA0;
        k++;
      end
    chk(16'(n_st - n0), 16'(k), {tag, " R10 count"});
    chk(bus_rdata, st, {tag, " R7 status"});
    wr(0, 16'h50);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    int n0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(bus_rdata, ARR, "R1 read-array after reset");
    wr(0, 16'h70);
    chk(bus_rdata, 16'h80, "R1 R2 status after reset");
    wr(0, 16'hFF);
    chk(bus_rdata, ARR, "R2 0xFF selects array");

    // R3 unknown first-cycle codes
    n0 = n_st;
    for (int c = 0; c < 256; c++) begin
      if (c == 'hFF || c == 'h70 || c == 'h50 || c == 'h40 || c == 'h20 || c == 'hA7 || c == 'h77) continue;
      wr(0, 16'(c));
      chk(bus_rdata, 16'hB0, $sformatf("R3 code %h", c));
      wr(0, 16'h50);
      chk(bus_rdata, 16'h80, "R8 clear after R3");
    end
    chk(16'(n_st - n0), 16'd0, "R3 no start");

    // R4 / R5 second-cycle sweep
    n0 = n_st;
    foreach (lk[i]) ;
    for (int f = 0; f < 3; f++) begin
      logic [7:0] fc = (f == 0) ? 8'h20 : (f == 1) ? 8'hA7 : 8'h77;
      for (int d = 0; d < 256; d++) begin
        if (d == 'hD0) continue;
        wr(0, {8'h00, fc}); wr(0, 16'(d) | 16'h3300);
        if (d == 'hFF) begin
          chk(bus_rdata, ARR, "R5 cancel to read-array");
          wr(0, 16'h70);
          chk(bus_rdata, 16'h80, "R5 cancel no flag");
        end else begin
          chk(bus_rdata, 16'hB0, $sformatf("R4 cmd %h data %h", fc, d));
          wr(0, 16'h50);
        end
      end
    end
    chk(16'(n_st - n0), 16'd0, "R4 R5 no start");

    // R13 R7 R9 program per block, pass and fail
    for (int b = 0; b < NB; b++)
      for (int f = 0; f < 2; f++) begin
        fail_mask = f ? '1 : '0;
        n0 = n_st;
        wr(0, 16'h40); wr(baddr(b), 16'h1234 + 16'(b * 3 + f));
        chk({15'd0, bus_rdata[7]}, 16'd0, "R9 busy after second cycle");
        wait_ready("R9 program completes");
        chk(bus_rdata, f ? 16'h90 : 16'h80, "R7 R9 program status with ready");
        chk({14'd0, log_op[n0 % 64]}, 16'd0, "R13 program op");
        chk({14'd0, log_blk[n0 % 64]}, 16'(b), "R13 program block");
        chk({8'd0, log_addr[n0 % 64]}, {8'd0, baddr(b)}, "R13 program addr");
        chk(log_data[n0 % 64], 16'h1234 + 16'(b * 3 + f), "R13 program data");
        if (f) begin
          wr(0, 16'h40);
          chk(bus_rdata, 16'hB0, "R8 program rejected while flagged");
          wr(0, 16'hFF);
          wr(0, 16'h70);
          chk(bus_rdata, 16'hB0, "R8 flags sticky");
          chk(16'(n_st - n0), 16'd1, "R8 no start while flagged");
          wr(0, 16'h50);
        end
      end

    // R7 block erase pass/fail
    for (int b = 0; b < NB; b++) begin
      fail_mask = 4'(1 << b) & 4'b0101;
      n0 = n_st;
      wr(0, 16'h20); wr(baddr(b), 16'h00D0);
      wait_ready("R7 erase completes");
      chk(bus_rdata, fail_mask[b] ? 16'hA0 : 16'h80, "R7 erase status");
      chk({14'd0, log_blk[n0 % 64]}, 16'(b), "R7 erase block");
      wr(0, 16'h50);
    end
    fail_mask = '0;

    // R12 writes while busy
    n0 = n_st;
    wr(0, 16'h20); wr(baddr(3), 16'h00D0);
    wr(0, 16'hFF); wr(0, 16'h40); wr(0, 16'h11);
    chk({15'd0, bus_rdata[7]}, 16'd0, "R12 still busy, status mode kept");
    wait_ready("R12 completes");
    chk(bus_rdata, 16'h80, "R12 busy writes ignored");
    chk(16'(n_st - n0), 16'd1, "R12 single start");

    // R11 lock bit program: fail leaves unlocked, pass locks
    fail_mask = 4'b0010;
    wr(0, 16'h77); wr(baddr(1), 16'h00D0);
    wait_ready("R11 lock fail completes");
    chk(bus_rdata, 16'h90, "R7 lock fail program flag");
    chk({14'd0, log_op[(n_st - 1) % 64]}, 16'd2, "R13 lock op");
    wr(0, 16'h50);
    fail_mask = '0;
    n0 = n_st;
    wr(0, 16'h20); wr(baddr(1), 16'h00D0);
    wait_ready("R11 erase unlocked");
    chk(bus_rdata, 16'h80, "R11 failed lock leaves block unlocked");
    chk(16'(n_st - n0), 16'd1, "R11 erase started");
    wr(0, 16'h77); wr(baddr(2), 16'h00D0);
    wait_ready("R11 lock pass");
    lk[2] = 1;
    n0 = n_st;
    wr(0, 16'h20); wr(baddr(2), 16'h00D0);
    chk(bus_rdata, 16'hA0, "R6 R11 locked erase error");
    chk(16'(n_st - n0), 16'd0, "R6 locked erase no start");
    wr(0, 16'h50);
    lock_dis = 1;
    wr(0, 16'h20); wr(baddr(2), 16'h00D0);
    wait_ready("R6 lock-disable erase");
    chk(bus_rdata, 16'h80, "R6 lock-disable no error");
    chk(16'(n_st - n0), 16'd1, "R6 lock-disable erase started");
    lock_dis = 0;

    // R10 erase all across growing lock patterns
    for (int step = 0; step < 3; step++) begin
      lock_dis = 0; erase_all_check($sformatf("R10 step %0d dis0", step));
      lock_dis = 1; erase_all_check($sformatf("R10 step %0d dis1", step));
      lock_dis = 0;
      if (step == 0) begin
        fail_mask = 4'b0010;
        erase_all_check("R10 fail mid-walk");
        fail_mask = '0;
      end
      for (int b = 0; b < NB; b++)
        if (!lk[b] && (step == 0 ? b == 0 : (b == 1 || b == 3))) begin
          wr(0, 16'h77); wr(baddr(b), 16'h00D0);
          wait_ready("R11 lock step");
          lk[b] = 1;
        end
    end

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule